// File: doc/BRIEF.md
# Dual-Clock FIFO with Half-Full Flag

This block carries a stream of data words from one clock domain into another, where the two clocks are unrelated but run at roughly the same rate. It holds sixteen entries by default. The producer pushes through a valid/ready handshake on the write clock. The consumer pops through a valid/ready handshake on the read clock. The read side also gets a half-full flag, so a consumer can decide when to start draining a burst.

Each side owns a binary pointer that is one bit wider than the address. The extra bit is a wrap bit, and it separates a full queue from an empty one. Each pointer crosses into the other domain as a reflected Gray code through two flops. Because no counter can be shared between the two clocks, the read side converts the synchronized write pointer back to binary and subtracts its own pointer from it. The result is the occupancy, and half-full is decoded from that number.

Back-pressure rules:
- A word is taken on a write-clock edge only when `in_valid` and `in_ready` are both high.
- A word leaves on a read-clock edge only when `out_valid` and `out_ready` are both high.
- `out_data` shows the oldest word whenever `out_valid` is high.

Top module: `xclk_fifo`

## Requirements
- R1: After both resets are released, `rd_empty` is 1, `out_valid` is 0, `half_full` is 0, `wr_full` is 0 and `in_ready` is 1.
- R2: Words leave on `out_data` in exactly the order in which they were accepted, across any number of pointer wraps.
- R3: When 16 words are held, `wr_full` is 1 and `in_ready` is 0. A push offered in that state is not stored, and the write pointer does not move.
- R4: While `rd_empty` is 1, `out_valid` is 0. A pop requested in that state does not move the read pointer, and it does not disturb the next word written.
- R5: Once both domains have settled, `half_full` is 1 exactly when the occupancy is 8 or more (8 to 16 entries). It is 0 for 0 to 7 entries. Because of the synchronizers, it may trail the true count by one or two words.
- R6: Once settled, `rd_empty` is 1 only at occupancy 0 and `wr_full` is 1 only at occupancy 16. The wrap bit tells these two cases apart even though their address bits match.
- R7: A pointer crossing domains is a 5-bit reflected Gray code: binary b maps to b XOR (b>>1), so 0,1,2,3 become 00000,00001,00011,00010. Between consecutive write clocks, the registered write Gray pointer changes in at most one bit.
- R8: A word accepted on a write-clock edge makes `out_valid` high within three read-clock edges after it.
- R9: The occupancy computed on the read side never exceeds 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain active-low reset |
| in_valid | input | 1 | Producer offers `in_data` |
| in_ready | output | 1 | FIFO can accept a word (not full) |
| in_data | input | DATA_W | Word being pushed |
| wr_full | output | 1 | All 16 entries hold data (write-side view) |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain active-low reset |
| out_valid | output | 1 | `out_data` holds the oldest word |
| out_ready | input | 1 | Consumer takes the word on this edge |
| out_data | output | DATA_W | Oldest stored word |
| rd_empty | output | 1 | No entry visible to the read side |
| half_full | output | 1 | Read-side occupancy is at least half the depth |

## Verification
The bench sweeps every fill level from 0 to 16 and drains completely after each level. The pointers therefore wrap many times and pass through every address alignment. A design that confused full with empty at equal addresses, or that made a Gray or binary conversion mistake, would show up as a wrong flag or as words out of order. At 16 entries the bench offers one more push, and on an empty queue it holds `out_ready` high. A design that let either of these through would return a stray word or lose order later. The bench also checks `half_full` at occupancies 7 and 8 in both directions and checks that a single push reaches `out_valid` within three read edges. A decoder that was off by one, or a synchronizer with extra stages, would fail these checks.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;
  // Pointer width: address bits plus one wrap bit.
  function automatic int unsigned ptr_width(int unsigned addr_w);
    return addr_w + 1;
  endfunction

  // Occupancy at which the half-full flag turns on.
  function automatic int unsigned half_level(int unsigned addr_w);
    return 1 << (addr_w - 1);
  endfunction
endpackage

// File: rtl/xfifo_sync.sv
module xfifo_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      q        <= '0;
    end else begin
      stage1_q <= d;
      q        <= stage1_q;
    end
  end
endmodule

// File: rtl/xfifo_g2b.sv
module xfifo_g2b #(
  parameter int W = 5
) (
  input  logic [W-1:0] gray,
  output logic [W-1:0] bin
);
  // Each binary bit is the parity of all Gray bits at and above it.
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bin[i] = ^gray[W-1:i];
  end
endmodule

// File: rtl/xfifo_mem.sv
module xfifo_mem #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/xfifo_wside.sv
module xfifo_wside #(
  parameter int ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push_req,
  input  logic [ADDR_W:0]       far_gray,
  output logic [ADDR_W:0]       gray_q,
  output logic [ADDR_W-1:0]     addr,
  output logic                  push_ok,
  output logic                  full
);
  localparam int PW = xfifo_pkg::ptr_width(ADDR_W);

  logic [PW-1:0] bin_q;
  logic [PW-1:0] bin_nx;
  logic [PW-1:0] full_pat;

  // Full: the read pointer is one lap behind, so the Gray codes differ in the top two bits only.
  assign full_pat = {~far_gray[PW-1:PW-2], far_gray[PW-3:0]};
  assign full     = (gray_q == full_pat);
  assign push_ok  = push_req && !full;
  assign bin_nx   = bin_q + PW'(push_ok);
  assign addr     = bin_q[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_nx;
      gray_q <= bin_nx ^ (bin_nx >> 1);
    end
  end
endmodule

// File: rtl/xfifo_rside.sv
module xfifo_rside #(
  parameter int ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pop_req,
  input  logic [ADDR_W:0]       far_gray,
  output logic [ADDR_W:0]       gray_q,
  output logic [ADDR_W-1:0]     addr,
  output logic                  empty,
  output logic [ADDR_W:0]       occ,
  output logic                  half
);
  localparam int PW   = xfifo_pkg::ptr_width(ADDR_W);
  localparam int HALF = xfifo_pkg::half_level(ADDR_W);

  logic [PW-1:0] bin_q;
  logic [PW-1:0] bin_nx;
  logic [PW-1:0] far_bin;
  logic          pop_ok;

  xfifo_g2b #(.W(PW)) u_g2b (
    .gray (far_gray),
    .bin  (far_bin)
  );

  assign empty  = (gray_q == far_gray);
  assign pop_ok = pop_req && !empty;
  assign bin_nx = bin_q + PW'(pop_ok);
  assign addr   = bin_q[ADDR_W-1:0];
  assign occ    = far_bin - bin_q;
  assign half   = (occ >= PW'(HALF));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_nx;
      gray_q <= bin_nx ^ (bin_nx >> 1);
    end
  end
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              wr_full,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              rd_empty,
  output logic              half_full
);
  localparam int PW = xfifo_pkg::ptr_width(ADDR_W);

  logic [PW-1:0]     w_gray;
  logic [PW-1:0]     r_gray;
  logic [PW-1:0]     w_gray_at_rd;
  logic [PW-1:0]     r_gray_at_wr;
  logic [PW-1:0]     rd_occ;
  logic [ADDR_W-1:0] w_addr;
  logic [ADDR_W-1:0] r_addr;
  logic              w_push;

  xfifo_wside #(.ADDR_W(ADDR_W)) u_wside (
    .clk      (wr_clk),
    .rst_n    (wr_rst_n),
    .push_req (in_valid),
    .far_gray (r_gray_at_wr),
    .gray_q   (w_gray),
    .addr     (w_addr),
    .push_ok  (w_push),
    .full     (wr_full)
  );

  xfifo_sync #(.W(PW)) u_w2r (
    .clk   (rd_clk),
    .rst_n (rd_rst_n),
    .d     (w_gray),
    .q     (w_gray_at_rd)
  );

  xfifo_sync #(.W(PW)) u_r2w (
    .clk   (wr_clk),
    .rst_n (wr_rst_n),
    .d     (r_gray),
    .q     (r_gray_at_wr)
  );

  xfifo_rside #(.ADDR_W(ADDR_W)) u_rside (
    .clk      (rd_clk),
    .rst_n    (rd_rst_n),
    .pop_req  (out_ready),
    .far_gray (w_gray_at_rd),
    .gray_q   (r_gray),
    .addr     (r_addr),
    .empty    (rd_empty),
    .occ      (rd_occ),
    .half     (half_full)
  );

  xfifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk   (wr_clk),
    .we    (w_push),
    .waddr (w_addr),
    .wdata (in_data),
    .raddr (r_addr),
    .rdata (out_data)
  );

  assign in_ready  = !wr_full;
  assign out_valid = !rd_empty;
endmodule

// File: rtl/xclk_fifo_chk.sv
module xclk_fifo_chk #(
  parameter int ADDR_W = 4
) (
  input logic          wr_clk,
  input logic          wr_rst_n,
  input logic          rd_clk,
  input logic          rd_rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_ready,
  input logic          rd_empty,
  input logic          half_full,
  input logic [ADDR_W:0] w_gray,
  input logic [ADDR_W:0] r_gray,
  input logic [ADDR_W:0] rd_occ
);
  localparam int DEPTH = 1 << ADDR_W;

  assert_gray_step_R7: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $countones(w_gray ^ $past(w_gray)) <= 1);

  assert_no_overflow_R3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (in_valid && !in_ready) |=> $stable(w_gray));

  assert_no_underflow_R4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (out_ready && rd_empty) |=> $stable(r_gray));

  assert_half_needs_data_R5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    half_full |-> !rd_empty);

  assert_occ_bound_R9: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_occ <= (ADDR_W+1)'(DEPTH));
endmodule

bind xclk_fifo xclk_fifo_chk #(.ADDR_W(ADDR_W)) chk_i (
  .wr_clk    (wr_clk),
  .wr_rst_n  (wr_rst_n),
  .rd_clk    (rd_clk),
  .rd_rst_n  (rd_rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_ready (out_ready),
  .rd_empty  (rd_empty),
  .half_full (half_full),
  .w_gray    (w_gray),
  .r_gray    (r_gray),
  .rd_occ    (rd_occ)
);

// File: tb/xclk_fifo_tb_top.sv
module xclk_fifo_tb_top;
  localparam int WR_PERIOD = 10;
  localparam int RD_PERIOD = 13;
  localparam int DEPTH     = 16;

  logic       wr_clk = 0, rd_clk = 0;
  logic       wr_rst_n = 0, rd_rst_n = 0;
  logic       in_valid = 0, out_ready = 0;
  logic [7:0] in_data = '0;
  logic       in_ready, wr_full, out_valid, rd_empty, half_full;
  logic [7:0] out_data;

  int checks = 0, errors = 0;
  int wr_seq = 0, rd_seq = 0;
  bit done = 0;

  always #(WR_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2) rd_clk = ~rd_clk;

  xclk_fifo dut_i (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .wr_full(wr_full), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .rd_empty(rd_empty), .half_full(half_full)
  );

  function automatic logic [7:0] word_of(int k);
    return 8'((k * 37 + 11) & 8'hFF);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge wr_clk);
    repeat (4) @(posedge rd_clk);
    @(negedge rd_clk);
  endtask

  task automatic push_one(input logic [7:0] d, output bit taken);
    @(negedge wr_clk);
    in_valid = 1; in_data = d;
    taken = in_ready;
    @(negedge wr_clk);
    in_valid = 0;
  endtask

  task automatic pop_one(output bit got, output logic [7:0] d);
    @(negedge rd_clk);
    got = out_valid; d = out_data;
    out_ready = 1;
    @(negedge rd_clk);
    out_ready = 0;
  endtask

  task automatic flags_at(input int n);
    settle();
    check(half_full == (n >= 8), $sformatf("R5 half_full at level %0d", n), half_full, n >= 8);
    check(rd_empty == (n == 0), $sformatf("R6 rd_empty at level %0d", n), rd_empty, n == 0);
    check(out_valid == (n != 0), $sformatf("R4 out_valid at level %0d", n), out_valid, n != 0);
    check(wr_full == (n == DEPTH), $sformatf("R6 wr_full at level %0d", n), wr_full, n == DEPTH);
    check(in_ready == (n < DEPTH), $sformatf("R3 in_ready at level %0d", n), in_ready, n < DEPTH);
  endtask

  initial begin
    bit ok;
    logic [7:0] d;
    repeat (3) @(posedge wr_clk);
    wr_rst_n = 1;
    rd_rst_n = 1;
    settle();
    // R1 reset state
    check(rd_empty == 1,  "R1 rd_empty", rd_empty, 1);
    check(out_valid == 0, "R1 out_valid", out_valid, 0);
    check(half_full == 0, "R1 half_full", half_full, 0);
    check(wr_full == 0,   "R1 wr_full", wr_full, 0);
    check(in_ready == 1,  "R1 in_ready", in_ready, 1);

    // Sweep every fill level; pointers wrap repeatedly (R7 Gray crossing exercised by order checks).
    for (int n = 0; n <= DEPTH; n++) begin
      for (int k = 0; k < n; k++) begin
        push_one(word_of(wr_seq), ok);
        check(ok, "R3 push accepted below full", ok, 1);
        wr_seq++;
      end
      flags_at(n);
      if (n == DEPTH) begin
        push_one(8'hEE, ok);
        check(!ok, "R3 push refused when full", ok, 0);
        flags_at(n);
      end
      for (int left = n; left > 0; left--) begin
        pop_one(ok, d);
        check(ok, "R2 word available", ok, 1);
        check(d == word_of(rd_seq), "R2 order R7 wrap", d, word_of(rd_seq));
        rd_seq++;
        if (left - 1 == 8 || left - 1 == 7) flags_at(left - 1);
      end
      flags_at(0);
      // R4 pop attempts on empty
      @(negedge rd_clk);
      out_ready = 1;
      repeat (3) begin
        @(negedge rd_clk);
        check(out_valid == 0, "R4 out_valid stays low", out_valid, 0);
      end
      out_ready = 0;
    end

    // R8 latency and R4 follow-up: one word after empty pops
    push_one(word_of(wr_seq), ok);
    wr_seq++;
    repeat (3) @(posedge rd_clk);
    @(negedge rd_clk);
    check(out_valid == 1, "R8 out_valid within three read edges", out_valid, 1);
    pop_one(ok, d);
    check(d == word_of(rd_seq), "R4 word after empty pops", d, word_of(rd_seq));
    rd_seq++;
    flags_at(0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    done = 1;
    $finish;
  end

  initial begin
    #(WR_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule